// File: doc/BRIEF.md
# Gated-Window Frequency Counter

This block measures how often an external signal rises. The signal is brought into the system clock domain through a two-flop synchroniser, and a rising-edge detector turns each low-to-high transition into a single-cycle pulse. A pulse is counted only if three conditions hold together: the pulse is present, the internally timed sample window is open, and the caller's arm level is high. Counting is done by a cascade of decimal digits. Each digit runs from 0 to 9 and passes a carry to the next digit when it wraps.

The window stays open for `WIN_CYCLES` system clocks and is followed by two closed cycles. In the first closed cycle, the capture cycle, every digit and the overflow flag are copied into a held result register. A valid strobe announces the new result. In the second closed cycle, the clear cycle, the digits and the overflow flag are wiped, so the next window starts from zero. The input frequency is the captured count divided by the window duration (`WIN_CYCLES` times the clock period). The number of digits is the parameter `DIGITS`.

Top module: `gated_freq_counter`

## Requirements
- R1: An edge pulse is counted only in a cycle where the window is open (`win_o` = 1) and `arm_i` = 1. Pulses that arrive while `arm_i` = 0 leave the count unchanged.
- R2: The count is BCD. `result_o[4k+3:4k]` holds digit k, and digit 0 is the least significant. Every digit stays within 0 to 9. A digit advances when an edge is counted and all lower digits are 9.
- R3: `win_o` is high for exactly `WIN_CYCLES` consecutive cycles and then low for exactly 2 cycles (capture, then clear), repeating. The window is open from the release of reset.
- R4: At the capture cycle, all digits and the overflow flag are copied into the result register. `valid_o` goes high for exactly one cycle, the clear cycle that follows. `result_o` and `ovf_o` then hold their values until the next capture.
- R5: The clear pulse lasts one cycle and comes right after the capture. The next window counts from zero, so a window without edges reports 0 even after a non-zero measurement.
- R6: If a counted edge carries out of the top digit, the count wraps to zero and a sticky overflow flag is set. It is reported as `ovf_o` = 1 with that result and is cleared for the next window.
- R7: While `rst_ni` = 0, `result_o` = 0, `valid_o` = 0, `ovf_o` = 0 and the count is zero.
- R8: `sig_i` passes through two synchronising flops. Each low-to-high transition counts exactly once, however long the level is then held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it also times the sample window |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Signal whose rising edges are counted (asynchronous) |
| arm_i | input | 1 | Held qualifier; counting is allowed only while it is high |
| win_o | output | 1 | High while the sample window is open |
| result_o | output | 4*DIGITS | Captured BCD count, digit 0 in bits [3:0] |
| valid_o | output | 1 | One-cycle strobe marking a new captured result |
| ovf_o | output | 1 | Overflow flag captured with the result |

## Verification
The bench times its bursts of edges from `win_o` and pushes the count it expects for each window into a scoreboard. The cases it targets are these:

- **Clear.** A window without edges that follows a busy window must report 0. A design that skips the clear pulse would add the new count to the old one.
- **Carry boundary.** Counts of 99, 100 and 123 on two digits exercise the decimal carry. A binary counter, or a digit that is allowed past 9, would show codes such as 0x0A. A missing sticky flag would let the wrapped count 00 or 23 pass as a real reading.
- **Overflow reset.** A one-edge window after an overflow must report `ovf_o` = 0. A flag that is never cleared would stay at 1.
- **Arm and held level.** Bursts split by `arm_i`, and a level held high for many cycles, catch a design that ignores the arm input or counts the level rather than its edge.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  typedef enum logic [1:0] {
    PH_WIN = 2'd0,
    PH_CAP = 2'd1,
    PH_CLR = 2'd2
  } phase_e;

  localparam logic [3:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/fcnt_edge_sync.sv
module fcnt_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // [0],[1] synchroniser, [2] previous value for edge detect
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], sig_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  p_rise_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o)
    else $error("edge pulse longer than one cycle");
endmodule

// File: rtl/fcnt_window.sv
module fcnt_window #(
  parameter int WIN_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_o,
  output logic cap_o,
  output logic clr_o
);
  import fcnt_pkg::*;

  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  phase_e          ph_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_WIN;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_WIN: begin
          if (cnt_q == LAST) begin
            ph_q  <= PH_CAP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CAP:  ph_q <= PH_CLR;
        default: ph_q <= PH_WIN;
      endcase
    end
  end

  assign win_o = (ph_q == PH_WIN);
  assign cap_o = (ph_q == PH_CAP);
  assign clr_o = (ph_q == PH_CLR);

  p_cap_then_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> clr_o)
    else $error("clear does not follow capture");
  p_clr_then_win_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> win_o)
    else $error("window does not reopen after clear");
  p_phase_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({win_o, cap_o, clr_o}))
    else $error("phase decode not one-hot");
endmodule

// File: rtl/fcnt_bcd_chain.sv
module fcnt_bcd_chain #(
  parameter int DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_i,
  input  logic                  clr_i,
  output logic [4*DIGITS-1:0]   bcd_o,
  output logic                  ovf_o
);
  import fcnt_pkg::*;

  logic [DIGITS:0] carry;
  logic            ovf_q;

  assign carry[0] = inc_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    logic [3:0] dig_q;
    logic       top;

    assign top          = (dig_q == BCD_MAX);
    assign carry[k+1]   = carry[k] & top;
    assign bcd_o[4*k +: 4] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;
      else if (carry[k]) dig_q <= top ? 4'd0 : dig_q + 4'd1;
    end

    p_digit_bcd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dig_q <= BCD_MAX)
      else $error("digit %0d left decimal range", k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovf_q <= 1'b0;
    else if (clr_i)         ovf_q <= 1'b0;
    else if (carry[DIGITS]) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bcd_o == '0 && !ovf_o))
    else $error("count not zero after clear");
  p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(bcd_o))
    else $error("count moved without a counted edge");
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o)
    else $error("overflow flag dropped inside a window");
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int WIN_CYCLES = 1000,
  parameter int DIGITS     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sig_i,
  input  logic                arm_i,
  output logic                win_o,
  output logic [4*DIGITS-1:0] result_o,
  output logic                valid_o,
  output logic                ovf_o
);
  localparam int RW = 4 * DIGITS;

  logic          rise, win, cap, clr, inc, live_ovf;
  logic [RW-1:0] live_bcd;
  logic [RW-1:0] res_q;
  logic          ovf_q, vld_q;

  fcnt_edge_sync u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (sig_i), .rise_o (rise)
  );

  fcnt_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i (clk_i), .rst_ni (rst_ni), .win_o (win), .cap_o (cap), .clr_o (clr)
  );

  // three-way qualifier: edge, open window, armed
  assign inc = rise & win & arm_i;

  fcnt_bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (inc), .clr_i (clr),
    .bcd_o (live_bcd), .ovf_o (live_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cap;
      if (cap) begin
        res_q <= live_bcd;
        ovf_q <= live_ovf;
      end
    end
  end

  assign win_o    = win;
  assign result_o = res_q;
  assign ovf_o    = ovf_q;
  assign valid_o  = vld_q;

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("valid strobe longer than one cycle");
  p_valid_after_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> valid_o)
    else $error("capture not announced");
  p_result_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> ($stable(result_o) && $stable(ovf_o)))
    else $error("result changed outside capture");
  p_no_count_closed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win || !arm_i) |=> (live_bcd == $past(live_bcd) || $past(clr)))
    else $error("count advanced while gated off");
endmodule

// File: tb/sim_gated_freq_counter.sv
`timescale 1ns/1ps
module sim_gated_freq_counter;
  localparam int WIN = 600;
  localparam int DIG = 2;
  localparam int RW  = 4 * DIG;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sig_i = 1'b0;
  logic arm_i = 1'b1;
  logic win_o, valid_o, ovf_o;
  logic [RW-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [RW:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  gated_freq_counter #(.WIN_CYCLES(WIN), .DIGITS(DIG)) u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (sig_i), .arm_i (arm_i),
    .win_o (win_o), .result_o (result_o), .valid_o (valid_o), .ovf_o (ovf_o)
  );

  function automatic logic [RW:0] model(input int n);
    logic [RW:0] v;
    int m;
    int lim;
    lim = 1;
    for (int k = 0; k < DIG; k++) lim = lim * 10;
    v = '0;
    v[RW] = (n >= lim);
    m = n % lim;
    for (int k = 0; k < DIG; k++) begin
      v[4*k +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sig_i = 1'b1; repeat (2) @(negedge clk_i);
      sig_i = 1'b0; repeat (2) @(negedge clk_i);
    end
  endtask

  // waits for the next window to open, pushes the expected result, drives it
  task automatic run_window(input string tag, input int n_arm, input int n_off, input bit hold);
    while (win_o !== 1'b0) @(negedge clk_i);
    while (win_o !== 1'b1) @(negedge clk_i);
    exp_q.push_back(model(hold ? 1 : n_arm));
    tag_q.push_back(tag);
    repeat (3) @(negedge clk_i);
    if (hold) begin
      sig_i = 1'b1; repeat (300) @(negedge clk_i);
      sig_i = 1'b0;
    end else begin
      arm_i = 1'b1; pulses(n_arm);
      arm_i = 1'b0; pulses(n_off);
      arm_i = 1'b1;
    end
  endtask

  // monitor: scoreboard pop, strobe width, window shape, result hold
  int          hi_run = 0, lo_run = 0;
  bit          seen_low = 1'b0, prev_win = 1'b1, prev_vld = 1'b0;
  logic [RW:0] held = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        logic [RW:0] e;
        string t;
        chk("R4 valid outside closed phase", 32'(win_o), 32'd0);
        if (exp_q.size() == 0) begin
          chk("R4 unexpected result", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " result"}, 32'(result_o), 32'(e[RW-1:0]));
          chk({t, " R6 overflow"}, 32'(ovf_o), 32'(e[RW]));
        end
        held = {ovf_o, result_o};
      end else begin
        chk("R4 result held", 32'({ovf_o, result_o}), 32'(held));
      end
      if (prev_vld) chk("R4 strobe one cycle", 32'(valid_o), 32'd0);
      if (win_o) begin
        if (!prev_win && seen_low) chk("R3 closed length", 32'(lo_run), 32'd2);
        hi_run++;
        lo_run = 0;
      end else begin
        if (prev_win && seen_low) chk("R3 window length", 32'(hi_run), 32'(WIN));
        if (prev_win) seen_low = 1'b1;
        lo_run++;
        hi_run = 0;
      end
      prev_win = win_o;
      prev_vld = valid_o;
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk("R7 reset result", 32'(result_o), 32'd0);
    chk("R7 reset valid", 32'(valid_o), 32'd0);
    chk("R7 reset overflow", 32'(ovf_o), 32'd0);
    rst_ni = 1'b1;
    chk("R3 window open after reset", 32'(win_o), 32'd1);
    exp_q.push_back(model(0));
    tag_q.push_back("R7 first window idle");
    run_window("R1 seven edges", 7, 0, 1'b0);
    run_window("R2 thirty-seven edges", 37, 0, 1'b0);
    run_window("R1 arm drop mid window", 10, 5, 1'b0);
    run_window("R1 disarmed window", 0, 20, 1'b0);
    run_window("R8 held level", 0, 0, 1'b1);
    run_window("R2 top of range", 99, 0, 1'b0);
    run_window("R5 idle after busy", 0, 0, 1'b0);
    run_window("R6 wrap at hundred", 100, 0, 1'b0);
    run_window("R6 wrap past hundred", 123, 0, 1'b0);
    run_window("R6 overflow cleared", 1, 0, 1'b0);
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule